// File: doc/BRIEF.md
# Longest Prefix Match Forwarding Table

This block is the forwarding table of an IPv4 router datapath. It holds a set of route entries. Each entry has a valid flag, a 32-bit prefix value, a prefix length, a 32-bit next-hop address and a bitmap of output ports. A lookup takes a 32-bit destination address and returns the entry whose prefix covers the address with the most significant bits. The result carries a hit flag, the index of the winning entry, its next hop and its port bitmap. When no entry covers the address, the result raises an exception flag so the packet can go to the software path.

Control software loads entries through a single-cycle write port that addresses one entry by index. A lookup is accepted only while the block is idle. At the accepting edge the block takes a frozen copy of the whole table, so writes made later never alter a lookup already in flight. The scan controller then visits `LANES` entries per cycle over `ENTRIES/LANES` cycles, whatever the address or the table contents. It has three states:
- `ST_IDLE` moves to `ST_SCAN` on the *accept* transition (`lk_req` high).
- `ST_SCAN` moves to `ST_DONE` on the *last-group* transition, taken when the final group of lanes has been compared.
- `ST_DONE` presents the result for one cycle and returns to `ST_IDLE` on the unconditional *retire* transition.

Top module: `lpm_route_table`

## Requirements
- R1: After reset, every entry is invalid, `lk_busy` and `res_valid` are low, and any lookup misses.
- R2: An entry of length L (1 to 32) matches an address exactly when the address's upper L bits, counting from bit 31 downward, equal the upper L bits of the entry's prefix. The lower 32-L bits play no part.
- R3: A valid entry of length 0 is a default route that matches every address.
- R4: When several valid entries match, the result is the matching entry with the greatest effective length.
- R5: When the greatest effective length is shared by several matching entries, the one with the lowest index wins.
- R6: On a miss, `res_hit` is 0, `res_exception` is 1, and `res_index`, `res_nexthop` and `res_ports` are all zero. On a hit, `res_exception` is 0.
- R7: A request is accepted at a rising edge where `lk_req` is high and `lk_busy` is low. `res_valid` is high during the cycle that follows the `ENTRIES/LANES`-th rising edge after the accepting edge (8 with defaults).
- R8: `lk_req` is ignored while `lk_busy` is high. It starts no second lookup and does not alter the result of the lookup in flight.
- R9: A table write committed at the accepting edge or later is invisible to that lookup. It is visible to every lookup accepted after the write's edge.
- R10: A stored length greater than 32 behaves as a length of 32.
- R11: Writing an entry with `wr_valid` low removes it from all later lookups.
- R12: `res_valid` lasts exactly one cycle. `lk_busy` stays high from the accepting edge through the result cycle and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | $clog2(ENTRIES) | Index of the entry to write |
| wr_valid | input | 1 | Valid flag of the written entry |
| wr_prefix | input | 32 | Prefix value |
| wr_len | input | 6 | Prefix length, 0 to 63 (above 32 acts as 32) |
| wr_nexthop | input | 32 | Next-hop address |
| wr_ports | input | 4 | Output port bitmap |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Destination address to look up |
| lk_busy | output | 1 | A lookup is in progress; requests are ignored |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Some valid entry matched |
| res_exception | output | 1 | No entry matched; send to the exception path |
| res_index | output | $clog2(ENTRIES) | Index of the winning entry |
| res_nexthop | output | 32 | Next hop of the winning entry |
| res_ports | output | 4 | Port bitmap of the winning entry |

## Verification
The hardest case to reach from the ports is a table write that races a lookup. The write must land on the accepting edge or partway through the scan, and it must change which entry would win. The bench drives a write in the same cycle as the request, and another two cycles into the scan. Both writes add a longer covering prefix, so the in-flight result must still name the old winner, and the next lookup must name the new one. Beyond that, the bench sweeps every prefix length against single-bit flips of the prefix at every position, and it scans a randomly filled table with overlapping prefixes and duplicated lengths against an arithmetic model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 6;
    localparam int PORT_W = 4;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] prefix;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] nexthop;
        logic [PORT_W-1:0] ports;
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;

endpackage

// File: rtl/lpm_table_store.sv
module lpm_table_store
    import lpm_pkg::*;
#(
    parameter  int ENTRIES = 32,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  route_t           wr_ent,
    input  logic             snap_en,
    output route_t           frozen [ENTRIES]
);

    // Live table written by software.
    route_t live_q [ENTRIES];

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n) begin
                live_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                live_q[e] <= wr_ent;
            end
        end
    end

    // Frozen bank: copy of the live table as it stood before the
    // accepting edge; the scan reads only this copy.
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n) begin
                frozen[e] <= '0;
            end else if (snap_en) begin
                frozen[e] <= live_q[e];
            end
        end
    end

endmodule

// File: rtl/lpm_prefix_cmp.sv
module lpm_prefix_cmp
    import lpm_pkg::*;
(
    input  route_t            ent,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [LEN_W-1:0]  eff_len
);

    logic [ADDR_W-1:0] mask;

    always_comb begin
        // Lengths past the address width saturate at a full match.
        eff_len = (ent.len > LEN_W'(ADDR_W)) ? LEN_W'(ADDR_W) : ent.len;
        // Upper eff_len bits set; a zero length gives an empty mask.
        mask    = ~({ADDR_W{1'b1}} >> eff_len);
        hit     = ent.valid && (((addr ^ ent.prefix) & mask) == '0);
    end

endmodule

// File: rtl/lpm_scan_ctrl.sv
module lpm_scan_ctrl
    import lpm_pkg::*;
#(
    parameter  int ENTRIES = 32,
    parameter  int LANES   = 4,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  route_t            frozen [ENTRIES],
    output logic              snap_en,
    output logic              busy,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_exception,
    output logic [IDX_W-1:0]  res_index,
    output logic [ADDR_W-1:0] res_nexthop,
    output logic [PORT_W-1:0] res_ports
);

    localparam int GROUPS = ENTRIES / LANES;
    localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    scan_state_t       state_q, state_d;
    logic [GRP_W-1:0]  grp_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;
    logic              last_grp;

    logic              best_hit_q;
    logic [LEN_W-1:0]  best_len_q;
    logic [IDX_W-1:0]  best_idx_q;
    logic [ADDR_W-1:0] best_nh_q;
    logic [PORT_W-1:0] best_pt_q;

    logic              c_hit;
    logic [LEN_W-1:0]  c_len;
    logic [IDX_W-1:0]  c_idx;
    logic [ADDR_W-1:0] c_nh;
    logic [PORT_W-1:0] c_pt;

    logic [IDX_W-1:0]  lane_idx   [LANES];
    route_t            lane_ent   [LANES];
    logic              lane_match [LANES];
    logic [LEN_W-1:0]  lane_len   [LANES];

    assign accept   = (state_q == ST_IDLE) && lk_req;
    assign last_grp = (grp_q == GRP_W'(GROUPS - 1));

    // One comparator per lane; the lanes cover consecutive indices.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_idx[l] = IDX_W'(int'(grp_q) * LANES + l);
        assign lane_ent[l] = frozen[lane_idx[l]];

        lpm_prefix_cmp u_cmp (
            .ent     (lane_ent[l]),
            .addr    (addr_q),
            .hit     (lane_match[l]),
            .eff_len (lane_len[l])
        );
    end

    // Running best: a strictly longer match replaces the holder, so
    // ascending index order keeps the lowest index on equal length.
    always_comb begin
        c_hit = best_hit_q;
        c_len = best_len_q;
        c_idx = best_idx_q;
        c_nh  = best_nh_q;
        c_pt  = best_pt_q;
        for (int l = 0; l < LANES; l++) begin
            if (lane_match[l] && (!c_hit || (lane_len[l] > c_len))) begin
                c_hit = 1'b1;
                c_len = lane_len[l];
                c_idx = lane_idx[l];
                c_nh  = lane_ent[l].nexthop;
                c_pt  = lane_ent[l].ports;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, last-group, retire.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lk_req)   state_d = ST_SCAN;
            ST_SCAN: if (last_grp) state_d = ST_DONE;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // Scan datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q      <= '0;
            addr_q     <= '0;
            best_hit_q <= 1'b0;
            best_len_q <= '0;
            best_idx_q <= '0;
            best_nh_q  <= '0;
            best_pt_q  <= '0;
        end else if (accept) begin
            grp_q      <= '0;
            addr_q     <= lk_addr;
            best_hit_q <= 1'b0;
            best_len_q <= '0;
            best_idx_q <= '0;
            best_nh_q  <= '0;
            best_pt_q  <= '0;
        end else if (state_q == ST_SCAN) begin
            grp_q      <= grp_q + 1'b1;
            best_hit_q <= c_hit;
            best_len_q <= c_len;
            best_idx_q <= c_idx;
            best_nh_q  <= c_nh;
            best_pt_q  <= c_pt;
        end
    end

    // Outputs.
    always_comb begin
        snap_en       = accept;
        busy          = (state_q != ST_IDLE);
        res_valid     = (state_q == ST_DONE);
        res_hit       = best_hit_q;
        res_exception = (state_q == ST_DONE) && !best_hit_q;
        res_index     = best_idx_q;
        res_nexthop   = best_nh_q;
        res_ports     = best_pt_q;
    end

endmodule

// File: rtl/lpm_route_table.sv
module lpm_route_table
    import lpm_pkg::*;
#(
    parameter  int ENTRIES = 32,
    parameter  int LANES   = 4,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int GROUPS  = ENTRIES / LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_prefix,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [ADDR_W-1:0] wr_nexthop,
    input  logic [PORT_W-1:0] wr_ports,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_busy,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_exception,
    output logic [IDX_W-1:0]  res_index,
    output logic [ADDR_W-1:0] res_nexthop,
    output logic [PORT_W-1:0] res_ports
);

    route_t wr_ent;
    route_t frozen [ENTRIES];
    logic   snap_en;

    always_comb begin
        wr_ent.valid   = wr_valid;
        wr_ent.prefix  = wr_prefix;
        wr_ent.len     = wr_len;
        wr_ent.nexthop = wr_nexthop;
        wr_ent.ports   = wr_ports;
    end

    lpm_table_store #(.ENTRIES(ENTRIES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_ent  (wr_ent),
        .snap_en (snap_en),
        .frozen  (frozen)
    );

    lpm_scan_ctrl #(.ENTRIES(ENTRIES), .LANES(LANES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_req        (lk_req),
        .lk_addr       (lk_addr),
        .frozen        (frozen),
        .snap_en       (snap_en),
        .busy          (lk_busy),
        .res_valid     (res_valid),
        .res_hit       (res_hit),
        .res_exception (res_exception),
        .res_index     (res_index),
        .res_nexthop   (res_nexthop),
        .res_ports     (res_ports)
    );

endmodule

// File: rtl/lpm_route_table_chk.sv
module lpm_route_table_chk #(
    parameter int GROUPS = 8,
    parameter int NH_W   = 32,
    parameter int PT_W   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_req,
    input logic            lk_busy,
    input logic            res_valid,
    input logic            res_hit,
    input logic            res_exception,
    input logic [NH_W-1:0] res_nexthop,
    input logic [PT_W-1:0] res_ports
);

    // Edges elapsed since the last accepted request.
    logic [15:0] since_acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_acc_q <= '0;
        end else if (lk_req && !lk_busy) begin
            since_acc_q <= '0;
        end else if (lk_busy) begin
            since_acc_q <= since_acc_q + 16'd1;
        end
    end

    a_r7_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (since_acc_q == 16'(GROUPS)));

    a_r12_one_cycle_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r12_busy_covers_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> lk_busy);

    a_r8_scan_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_busy && !res_valid) |=> lk_busy);

    a_r6_miss_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_exception && res_nexthop == '0 && res_ports == '0));

    a_r6_exception_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_exception |-> (res_valid && !res_hit));

endmodule

bind lpm_route_table lpm_route_table_chk #(
    .GROUPS (GROUPS),
    .NH_W   (lpm_pkg::ADDR_W),
    .PT_W   (lpm_pkg::PORT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_req        (lk_req),
    .lk_busy       (lk_busy),
    .res_valid     (res_valid),
    .res_hit       (res_hit),
    .res_exception (res_exception),
    .res_nexthop   (res_nexthop),
    .res_ports     (res_ports)
);

// File: tb/lpm_route_table_bench.sv
module lpm_route_table_bench;

    localparam int N    = 32;
    localparam int GRPS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_prefix = '0;
    logic [5:0]  wr_len = '0;
    logic [31:0] wr_nexthop = '0;
    logic [3:0]  wr_ports = '0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_busy, res_valid, res_hit, res_exception;
    logic [4:0]  res_index;
    logic [31:0] res_nexthop;
    logic [3:0]  res_ports;

    always #2.5 clk = ~clk;

    lpm_route_table u_lpm_route_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_prefix(wr_prefix), .wr_len(wr_len),
        .wr_nexthop(wr_nexthop), .wr_ports(wr_ports), .lk_req(lk_req),
        .lk_addr(lk_addr), .lk_busy(lk_busy), .res_valid(res_valid),
        .res_hit(res_hit), .res_exception(res_exception),
        .res_index(res_index), .res_nexthop(res_nexthop), .res_ports(res_ports)
    );

    int nvec = 0;
    int nbad = 0;
    int cyc  = 0;
    int acc_cyc;
    logic        e_hit;
    logic [4:0]  e_idx;
    logic [31:0] e_nh;
    logic [3:0]  e_pt;

    logic        m_valid [N];
    logic [31:0] m_prefix[N];
    logic [5:0]  m_len   [N];
    logic [31:0] m_nh    [N];
    logic [3:0]  m_pt    [N];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic mdl_match(input int i, input logic [31:0] a);
        int L;
        L = (m_len[i] > 6'd32) ? 32 : int'(m_len[i]);
        if (!m_valid[i]) return 1'b0;
        if (L == 0) return 1'b1;
        return (a >> (32 - L)) == (m_prefix[i] >> (32 - L));
    endfunction

    task automatic mdl_lookup(input logic [31:0] a);
        int bl;
        e_hit = 1'b0; e_idx = '0; e_nh = '0; e_pt = '0; bl = -1;
        for (int i = 0; i < N; i++) begin
            int L;
            L = (m_len[i] > 6'd32) ? 32 : int'(m_len[i]);
            if (mdl_match(i, a) && L > bl) begin
                bl = L; e_hit = 1'b1; e_idx = 5'(i); e_nh = m_nh[i]; e_pt = m_pt[i];
            end
        end
    endtask

    task automatic drive_wr(input int i, input logic v, input logic [31:0] p,
                            input logic [5:0] l, input logic [31:0] nh, input logic [3:0] pt);
        wr_en = 1'b1; wr_idx = 5'(i); wr_valid = v; wr_prefix = p;
        wr_len = l; wr_nexthop = nh; wr_ports = pt;
        m_valid[i] = v; m_prefix[i] = p; m_len[i] = l; m_nh[i] = nh; m_pt[i] = pt;
    endtask

    task automatic wr_entry(input int i, input logic v, input logic [31:0] p,
                            input logic [5:0] l, input logic [31:0] nh, input logic [3:0] pt);
        @(negedge clk);
        drive_wr(i, v, p, l, nh, pt);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lk_start(input logic [31:0] a);
        @(negedge clk);
        check("R12 idle before request", {63'd0, lk_busy}, 64'd0);
        mdl_lookup(a);
        lk_req = 1'b1; lk_addr = a; acc_cyc = cyc + 1;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic lk_finish(input string tag);
        int guard;
        guard = 0;
        while (!res_valid && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        check("R7 result latency", 64'(cyc - acc_cyc), 64'(GRPS));
        check(tag, {21'd0, res_valid, res_hit, res_exception, res_index, res_nexthop, res_ports},
                   {21'd0, 1'b1, e_hit, !e_hit, e_idx, e_nh, e_pt});
        @(negedge clk);
        check("R12 result drops", {62'd0, res_valid, lk_busy}, 64'd0);
    endtask

    task automatic lookup(input logic [31:0] a, input string tag);
        lk_start(a);
        lk_finish(tag);
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) wr_entry(i, 1'b0, 32'd0, 6'd0, 32'd0, 4'd0);
    endtask

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] base [4];
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_prefix[i] = 0; m_len[i] = 0; m_nh[i] = 0; m_pt[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {62'd0, lk_busy, res_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {62'd0, lk_busy, res_valid}, 64'd0);
        lookup(32'h0A00_0001, "R1 empty table miss");
        lookup(32'hFFFF_FFFF, "R6 miss fields");

        // R2/R3: every length against single-bit flips at every position.
        for (int L = 0; L <= 32; L++) begin
            wr_entry(5, 1'b1, 32'hA5C3_0F96, 6'(L), 32'h1000_0000 + L, 4'(L));
            lookup(32'hA5C3_0F96, (L == 0) ? "R3 default exact" : "R2 exact address");
            for (int b = 0; b < 32; b++)
                lookup(32'hA5C3_0F96 ^ (32'd1 << b), (L == 0) ? "R3 default any" : "R2 bit flip");
        end

        // R10: lengths above 32 saturate.
        wr_entry(5, 1'b1, 32'h1234_5678, 6'd40, 32'hBEEF_0001, 4'h9);
        lookup(32'h1234_5678, "R10 over-length exact");
        lookup(32'h1234_5679, "R10 over-length lsb flip");
        wr_entry(5, 1'b1, 32'h1234_5678, 6'd63, 32'hBEEF_0002, 4'h6);
        lookup(32'h1234_5678, "R10 length 63 exact");
        lookup(32'h9234_5678, "R10 length 63 msb flip");

        // R4: nested prefixes in both index orders.
        clear_all();
        wr_entry(20, 1'b1, 32'h8009_0000, 6'd16, 32'h0A0A_0010, 4'h1);
        wr_entry(3,  1'b1, 32'h8009_1000, 6'd20, 32'h0A0A_0014, 4'h2);
        wr_entry(30, 1'b1, 32'h8009_1000, 6'd24, 32'h0A0A_0018, 4'h4);
        wr_entry(0,  1'b1, 32'h0000_0000, 6'd0,  32'h0A0A_0000, 4'h8);
        lookup(32'h8009_100E, "R4 longest of four");
        lookup(32'h8009_1F0E, "R4 /20 beats /16");
        lookup(32'h8009_FF0E, "R4 /16 beats default");
        lookup(32'h4000_0001, "R3 default only");

        // R5 and R11: equal lengths, then removal of the winner.
        wr_entry(7,  1'b1, 32'hC0A8_0100, 6'd24, 32'hC0A8_0007, 4'h3);
        wr_entry(12, 1'b1, 32'hC0A8_01FF, 6'd24, 32'hC0A8_000C, 4'h5);
        lookup(32'hC0A8_0142, "R5 lower index on tie");
        wr_entry(7, 1'b0, 32'hC0A8_0100, 6'd24, 32'hC0A8_0007, 4'h3);
        lookup(32'hC0A8_0142, "R11 removed entry skipped");
        wr_entry(12, 1'b0, 32'd0, 6'd0, 32'd0, 4'd0);
        wr_entry(0,  1'b0, 32'd0, 6'd0, 32'd0, 4'd0);
        lookup(32'hC0A8_0142, "R11 all removed miss");

        // R8: requests during a scan are ignored.
        lk_start(32'h8009_100E);
        lk_req = 1'b1; lk_addr = 32'h8009_FF00;
        @(negedge clk);
        @(negedge clk);
        lk_req = 1'b0;
        lk_finish("R8 in-flight result kept");
        begin
            int extra;
            extra = 0;
            repeat (GRPS + 4) begin
                @(negedge clk);
                if (res_valid) extra++;
            end
            check("R8 no second result", 64'(extra), 64'd0);
        end

        // R9: write during scan and write on the accepting edge.
        lk_start(32'h8009_2233);
        wr_entry(9, 1'b1, 32'h8009_2200, 6'd24, 32'h0909_0909, 4'hA);
        lk_finish("R9 mid-scan write hidden");
        lookup(32'h8009_2233, "R9 write seen next lookup");
        @(negedge clk);
        mdl_lookup(32'h8009_2233);
        lk_req = 1'b1; lk_addr = 32'h8009_2233; acc_cyc = cyc + 1;
        drive_wr(10, 1'b1, 32'h8009_2233, 6'd32, 32'h1010_1010, 4'hF);
        @(negedge clk);
        lk_req = 1'b0; wr_en = 1'b0;
        lk_finish("R9 same-edge write hidden");
        lookup(32'h8009_2233, "R9 host route seen later");

        // R4/R5 sweep on a random, heavily overlapping table.
        r = 32'h1F2E_3D4C;
        for (int k = 0; k < 4; k++) begin
            r = xs(r);
            base[k] = r;
        end
        for (int i = 0; i < N; i++) begin
            logic [5:0] l;
            r = xs(r);
            l = 6'(r % 35);
            if (i % 8 == 7) begin
                wr_entry(i, 1'b1, m_prefix[i-5], m_len[i-5], r, 4'(r >> 8));
            end else begin
                wr_entry(i, r[31] | r[30], base[i % 4] ^ (r >> (r[4:0] + 5'd8)), l,
                         xs(r), 4'(r >> 12));
            end
        end
        for (int k = 0; k < 400; k++) begin
            r = xs(r);
            lookup(base[k % 4] ^ (xs(r) >> r[4:0]), "R4 random table");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule